// File: doc/BRIEF.md
# Operand Hazard and Forwarding Control

This block sits beside the operand path of a four-stage pipeline (fetch, decode with register read, execute, write-back). Each cycle it compares the two source register numbers of the instruction in decode with the destination of the instruction in execute and with the destination of the instruction in write-back. From these comparisons it decides whether the decoded instruction may move into execute, and which operand path the ALU uses once it gets there.

A mode input picks one of two policies. In forwarding mode, a source that matches the instruction directly ahead is marked. During the consumer's execute cycle the operand select then chooses the result register, which holds the producer's result at that point, in place of the captured register-file value. A match with the write-back instruction needs no action, because the register file passes a same-cycle write through to its read ports. In stall-only mode, no forwarding happens. Decode and fetch are frozen, and a no-operation is placed in execute, for as long as a matching producer is still in execute or write-back. A busy execute stage, meaning a multi-cycle operation, freezes fetch and decode without inserting a bubble.

Top module: `hazard_fwd_unit`

## Requirements
- R1: While reset is low, and in the cycle after reset is released, both operand selects read 0 (register-file path).
- R2: In forwarding mode, if decode is valid, source 1 equals the execute destination, the execute instruction is valid and writes a register, the destination is non-zero and nothing stalls, then the source-1 select is 1 (result-register path) after the next clock edge. Otherwise it is 0.
- R3: Source 2 is checked on its own under the same rule as R2 and drives its own select. A match on one source never sets the other select.
- R4: Register 0, a producer that does not write, an invalid producer and an invalid decode slot never cause forwarding or a hazard stall.
- R5: In forwarding mode the bubble output is never asserted, and the stall output is asserted only when execute is busy.
- R6: In stall-only mode, a valid decode whose source matches a writing, valid, non-zero producer in execute or in write-back raises the stall and bubble outputs in that same cycle. The operand selects stay 0.
- R7: When execute is busy, the stall output is 1 and the bubble output is 0, whatever the hazard state, and both operand selects keep their values across the edge.
- R8: After a cycle with the bubble output asserted, both operand selects read 0.
- R9: In forwarding mode, a match only against the write-back instruction causes neither a stall nor a forward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fwd_en | input | 1 | 1 selects forwarding mode, 0 selects stall-only mode |
| ex_busy | input | 1 | Execute stage needs another cycle |
| d_valid | input | 1 | Decode holds a real instruction |
| d_rs1 | input | REG_W | Decode source register 1 |
| d_rs2 | input | REG_W | Decode source register 2 |
| e_valid | input | 1 | Execute holds a real instruction |
| e_wr | input | 1 | Execute instruction writes a register |
| e_rd | input | REG_W | Execute destination register |
| w_valid | input | 1 | Write-back holds a real instruction |
| w_wr | input | 1 | Write-back instruction writes a register |
| w_rd | input | REG_W | Write-back destination register |
| stall_fd | output | 1 | Freeze the fetch and decode buffers |
| bubble_e | output | 1 | Load a no-operation into the execute buffer |
| fwd_src1 | output | 1 | ALU operand 1 comes from the result register |
| fwd_src2 | output | 1 | ALU operand 2 comes from the result register |

## Verification
The properties assume that the pipeline around the block obeys its outputs. The stage fields move forward only on cycles without a stall. The result register is loaded only when execute finishes, so it stays stable while execute is busy. The mode input changes only between instructions, not while a stall is pending. The stimulus table sets each cycle's stage contents directly. It changes the mode only on cycles whose outcome it checks, and the stall-only sequence keeps the producer marching from execute to write-back while the consumer waits in decode.

// File: rtl/hfu_pkg.sv
// Shared definitions for the hazard and forwarding unit.
// Assumes two source operands per instruction.
package hfu_pkg;
    localparam int NSRC = 2;

    typedef enum logic {
        OPND_REGS = 1'b0,
        OPND_RSLT = 1'b1
    } opnd_sel_e;
endpackage

// File: rtl/hfu_match.sv
// Compares one source register number against one producer.
// Assumes register 0 is hard-wired and never creates a dependency.
module hfu_match #(
    parameter int REG_W = 5
) (
    input  logic             cons_valid,
    input  logic [REG_W-1:0] src,
    input  logic             prod_valid,
    input  logic             prod_wr,
    input  logic [REG_W-1:0] dst,
    output logic             hit
);
    // Dependency exists only for a real writing producer of a non-zero register.
    always_comb begin
        hit = cons_valid && prod_valid && prod_wr
              && (dst != '0) && (dst == src);
    end
endmodule

// File: rtl/hfu_hazard_ctl.sv
// Turns the per-source hit vectors into stall and bubble requests.
// Assumes ex_busy freezes execute, so no bubble may overwrite it.
module hfu_hazard_ctl #(
    parameter int NSRC = 2
) (
    input  logic            fwd_en,
    input  logic            ex_busy,
    input  logic [NSRC-1:0] hit_e,
    input  logic [NSRC-1:0] hit_w,
    output logic            stall,
    output logic            bubble,
    output logic            advance
);
    logic hazard;

    // Stall-only mode waits until any matching producer has left write-back.
    always_comb begin
        hazard  = !fwd_en && ((|hit_e) || (|hit_w));
        stall   = ex_busy || hazard;
        bubble  = hazard && !ex_busy;
        advance = !stall;
    end
endmodule

// File: rtl/hfu_sel_reg.sv
// Holds the operand path choice for the instruction now in execute.
// Assumes the result register holds the execute-ahead producer's result
// throughout the consumer's execute cycle.
module hfu_sel_reg
    import hfu_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fwd_en,
    input  logic            load,
    input  logic            clear,
    input  logic [NSRC-1:0] hit_e,
    output logic [NSRC-1:0] sel
);
    opnd_sel_e sel_q [NSRC];

    for (genvar s = 0; s < NSRC; s++) begin : g_sel
        // One operand path register per source: cleared by a bubble, held during a stall.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[s] <= OPND_REGS;
            end else if (clear) begin
                sel_q[s] <= OPND_REGS;
            end else if (load) begin
                sel_q[s] <= (fwd_en && hit_e[s]) ? OPND_RSLT : OPND_REGS;
            end
        end

        // Present the stored choice as a plain select bit.
        always_comb begin
            sel[s] = (sel_q[s] == OPND_RSLT);
        end
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
// Read-after-write control for a four-stage pipeline. It forwards the
// result register to the ALU inputs, or freezes decode and injects bubbles.
// Assumes the register file makes a same-cycle write visible to decode reads.
module hazard_fwd_unit
    import hfu_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_en,
    input  logic             ex_busy,
    input  logic             d_valid,
    input  logic [REG_W-1:0] d_rs1,
    input  logic [REG_W-1:0] d_rs2,
    input  logic             e_valid,
    input  logic             e_wr,
    input  logic [REG_W-1:0] e_rd,
    input  logic             w_valid,
    input  logic             w_wr,
    input  logic [REG_W-1:0] w_rd,
    output logic             stall_fd,
    output logic             bubble_e,
    output logic             fwd_src1,
    output logic             fwd_src2
);
    logic [REG_W-1:0] src [NSRC];
    logic [NSRC-1:0]  hit_e;
    logic [NSRC-1:0]  hit_w;
    logic [NSRC-1:0]  sel;
    logic             advance;

    // Gather the decode sources so the comparators can be generated.
    always_comb begin
        src[0] = d_rs1;
        src[1] = d_rs2;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_cmp
        hfu_match #(.REG_W(REG_W)) u_match_e (
            .cons_valid (d_valid),
            .src        (src[s]),
            .prod_valid (e_valid),
            .prod_wr    (e_wr),
            .dst        (e_rd),
            .hit        (hit_e[s])
        );
        hfu_match #(.REG_W(REG_W)) u_match_w (
            .cons_valid (d_valid),
            .src        (src[s]),
            .prod_valid (w_valid),
            .prod_wr    (w_wr),
            .dst        (w_rd),
            .hit        (hit_w[s])
        );
    end

    hfu_hazard_ctl #(.NSRC(NSRC)) u_ctl (
        .fwd_en  (fwd_en),
        .ex_busy (ex_busy),
        .hit_e   (hit_e),
        .hit_w   (hit_w),
        .stall   (stall_fd),
        .bubble  (bubble_e),
        .advance (advance)
    );

    hfu_sel_reg #(.NSRC(NSRC)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .fwd_en (fwd_en),
        .load   (advance),
        .clear  (bubble_e),
        .hit_e  (hit_e),
        .sel    (sel)
    );

    // Drive the per-operand select ports.
    always_comb begin
        fwd_src1 = sel[0];
        fwd_src2 = sel[1];
    end
endmodule

// File: rtl/hfu_checker.sv
// Temporal properties of the hazard and forwarding unit, bound to the top.
// Assumes rst_n low for at least one edge at start-up.
module hfu_checker #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fwd_en,
    input logic             ex_busy,
    input logic             d_valid,
    input logic [REG_W-1:0] d_rs1,
    input logic             e_valid,
    input logic             e_wr,
    input logic [REG_W-1:0] e_rd,
    input logic             stall_fd,
    input logic             bubble_e,
    input logic             fwd_src1,
    input logic             fwd_src2
);
    p_busy_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ex_busy |-> (stall_fd && !bubble_e));

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ex_busy |=> ($stable(fwd_src1) && $stable(fwd_src2)));

    p_bubble_needs_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_e |-> stall_fd);

    p_fwd_mode_no_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_en |-> !bubble_e);

    p_bubble_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_e |=> (!fwd_src1 && !fwd_src2));

    p_no_producer_no_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_fd && !(e_valid && e_wr)) |=> (!fwd_src1 && !fwd_src2));

    p_stall_mode_no_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwd_en && !stall_fd) |=> (!fwd_src1 && !fwd_src2));

    p_src1_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en && !stall_fd && d_valid && e_valid && e_wr
         && (e_rd != '0) && (e_rd == d_rs1)) |=> fwd_src1);
endmodule

bind hazard_fwd_unit hfu_checker #(.REG_W(REG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fwd_en   (fwd_en),
    .ex_busy  (ex_busy),
    .d_valid  (d_valid),
    .d_rs1    (d_rs1),
    .e_valid  (e_valid),
    .e_wr     (e_wr),
    .e_rd     (e_rd),
    .stall_fd (stall_fd),
    .bubble_e (bubble_e),
    .fwd_src1 (fwd_src1),
    .fwd_src2 (fwd_src2)
);

// File: tb/hazard_fwd_unit_test.sv
`timescale 1ns/100ps
module hazard_fwd_unit_test;
    localparam int REG_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fwd_en = 1'b1, ex_busy = 1'b0, d_valid = 1'b0;
    logic [REG_W-1:0] d_rs1 = '0, d_rs2 = '0, e_rd = '0, w_rd = '0;
    logic e_valid = 1'b0, e_wr = 1'b0, w_valid = 1'b0, w_wr = 1'b0;
    logic stall_fd, bubble_e, fwd_src1, fwd_src2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hazard_fwd_unit #(.REG_W(REG_W)) uut (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en), .ex_busy(ex_busy),
        .d_valid(d_valid), .d_rs1(d_rs1), .d_rs2(d_rs2),
        .e_valid(e_valid), .e_wr(e_wr), .e_rd(e_rd),
        .w_valid(w_valid), .w_wr(w_wr), .w_rd(w_rd),
        .stall_fd(stall_fd), .bubble_e(bubble_e),
        .fwd_src1(fwd_src1), .fwd_src2(fwd_src2)
    );

    typedef struct packed {
        logic fwd; logic busy; logic dv;
        logic [4:0] rs1; logic [4:0] rs2;
        logic ev; logic ew; logic [4:0] erd;
        logic wv; logic ww; logic [4:0] wrd;
        logic st; logic bb; logic f1; logic f2;
    } vec_t;

    localparam int NV = 19;
    // Fields: mode, busy, d_valid, rs1, rs2, e valid/wr/rd, w valid/wr/rd,
    // expected stall, bubble (same cycle), expected selects (after the edge).
    localparam vec_t VECS [NV] = '{
        '{1,0,1, 3, 4, 1,1, 3, 0,0, 0, 0,0,1,0},
        '{1,0,1, 5, 3, 1,1, 3, 0,0, 0, 0,0,0,1},
        '{1,0,1, 6, 6, 1,1, 6, 0,0, 0, 0,0,1,1},
        '{1,0,1, 0, 0, 1,1, 0, 0,0, 0, 0,0,0,0},
        '{1,0,1, 7, 1, 1,0, 7, 0,0, 0, 0,0,0,0},
        '{1,0,1, 7, 1, 0,1, 7, 0,0, 0, 0,0,0,0},
        '{1,0,0, 7, 7, 1,1, 7, 0,0, 0, 0,0,0,0},
        '{1,0,1, 9, 1, 1,1, 2, 1,1, 9, 0,0,0,0},
        '{1,0,1, 9, 9, 1,1, 9, 1,1, 9, 0,0,1,1},
        '{1,1,1, 1, 1, 1,1, 1, 0,0, 0, 1,0,1,1},
        '{0,0,1, 4, 2, 1,1, 4, 0,0, 0, 1,1,0,0},
        '{0,0,1, 2, 4, 0,0, 0, 1,1, 4, 1,1,0,0},
        '{0,0,1, 8,10, 1,1,11, 1,1,12, 0,0,0,0},
        '{0,0,1, 0, 0, 1,1, 0, 1,1, 0, 0,0,0,0},
        '{0,0,1, 5, 5, 1,0, 5, 0,1, 5, 0,0,0,0},
        '{0,1,1, 5, 5, 1,1, 5, 0,0, 0, 1,0,0,0},
        '{1,0,1,12,13, 1,1,13, 0,0, 0, 0,0,0,1},
        '{1,1,0, 0, 0, 0,0, 0, 0,0, 0, 1,0,0,1},
        '{1,0,0, 0, 0, 0,0, 0, 0,0, 0, 0,0,0,0}
    };
    localparam string TAG_C [NV] = '{
        "R5","R5","R5","R4","R4","R4","R4","R9","R5","R7",
        "R6","R6","R6","R4","R4","R7","R5","R7","R5"};
    localparam string TAG_R [NV] = '{
        "R2","R3","R3","R4","R4","R4","R4","R9","R2","R7",
        "R8","R6","R6","R4","R4","R7","R3","R7","R4"};

    task automatic check2(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input vec_t v);
        fwd_en = v.fwd; ex_busy = v.busy; d_valid = v.dv;
        d_rs1 = v.rs1; d_rs2 = v.rs2;
        e_valid = v.ev; e_wr = v.ew; e_rd = v.erd;
        w_valid = v.wv; w_wr = v.ww; w_rd = v.wrd;
    endtask

    task automatic idle();
        fwd_en = 1'b1; ex_busy = 1'b0; d_valid = 1'b0;
        e_valid = 1'b0; e_wr = 1'b0; w_valid = 1'b0; w_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        // R1: state during and right after reset.
        repeat (3) @(posedge clk);
        #1 check2("R1", {fwd_src1, fwd_src2}, 2'b00);
        check2("R1", {stall_fd, bubble_e}, 2'b00);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 check2("R1", {fwd_src1, fwd_src2}, 2'b00);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk) drive(VECS[i]);
            #1 check2(TAG_C[i], {stall_fd, bubble_e}, {VECS[i].st, VECS[i].bb});
            @(posedge clk);
            #1 check2(TAG_R[i], {fwd_src1, fwd_src2}, {VECS[i].f1, VECS[i].f2});
        end

        // R6: stall-only sequence, producer in E then W, consumer waits two cycles.
        @(negedge clk) drive('{0,0,1,3,0, 1,1,3, 0,0,0, 0,0,0,0});
        #1 check2("R6", {stall_fd, bubble_e}, 2'b11);
        @(negedge clk) drive('{0,0,1,3,0, 0,0,0, 1,1,3, 0,0,0,0});
        #1 check2("R6", {stall_fd, bubble_e}, 2'b11);
        @(negedge clk) drive('{0,0,1,3,0, 0,0,0, 0,0,0, 0,0,0,0});
        #1 check2("R6", {stall_fd, bubble_e}, 2'b00);

        // R1: reset in mid-run clears set selects.
        @(negedge clk) drive('{1,0,1,6,6, 1,1,6, 0,0,0, 0,0,0,0});
        @(posedge clk); #1 check2("R2", {fwd_src1, fwd_src2}, 2'b11);
        @(negedge clk) begin idle(); rst_n = 1'b0; end
        @(posedge clk); #1 check2("R1", {fwd_src1, fwd_src2}, 2'b00);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 check2("R1", {fwd_src1, fwd_src2}, 2'b00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule